// File: doc/BRIEF.md
# Fixed-Duty Phase-Accumulator Clock Generator

This block turns a fast system clock into a slower square-wave clock whose rate is set by a 20-bit tuning word. Every system clock cycle in which the block is running, the tuning word is added to a 20-bit phase register. When that addition carries out of the top bit, the phase register keeps only the wrapped low 20 bits and the output clock changes level. Two carries make one output period, so the output runs at f_sys × tuning / 2^21 on average and spends equal time high and low over the long run.

In the intended use the system clock is 32 MHz. Tuning words of 2517, 10066, 120796 and 241592 then give roughly 38.4 kHz, 153.6 kHz, 1.8432 MHz and 3.6864 MHz, which are sixteen-times oversampling clocks for common serial bit rates. Software-side setup is expected to clear the phase register before enabling the block so that the output starts from a known phase.

Top module: `nco_clkgen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase register becomes zero and `clk_out` becomes 0.
- R2: In a running cycle (`run_en`=1, `phase_clr`=0), the phase register takes the value (phase + `tune_word`) mod 2^20 at the rising edge.
- R3: In a running cycle, `clk_out` inverts at the rising edge exactly when phase + `tune_word` ≥ 2^20, and keeps its level otherwise.
- R4: While `run_en`=0 and `phase_clr`=0, the phase register keeps its value and `clk_out` is driven to 0 at the next edge; after `run_en` returns to 1 the accumulation continues from the kept phase.
- R5: `phase_clr`=1 sets the phase register to zero and `clk_out` to 0 at the next edge, whatever the level of `run_en`.
- R6: A `tune_word` of zero produces no carries, so `clk_out` keeps its level while running.
- R7: Starting from a cleared phase, the number of `clk_out` level changes in N running cycles equals floor(N × `tune_word` / 2^20).
- R8: With `tune_word` = 2^19 from a cleared phase, `clk_out` has a period of exactly 4 system cycles, high for 2 and low for 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | 1 = accumulate and toggle; 0 = hold phase, output low |
| phase_clr | input | 1 | Synchronous clear of phase and output, overrides run_en |
| tune_word | input | 20 | Phase increment added each running cycle |
| clk_out | output | 1 | Generated square-wave clock, registered |

## Verification
The bench drives a bit-exact reference of the phase register, so a carry that is detected one cycle late, taken from the wrong bit, or computed on a truncated sum shows as an output level mismatch at a specific cycle. It pauses the block after a carry left a non-zero residual phase and then resumes with a word that only carries if that residual survived, which catches a design that clears or advances the phase while disabled. It asserts the clear together with the enable to catch a wrong priority, runs a zero word to catch spurious toggles, and counts output edges for the serial-rate tuning words over 2048 cycles, where a design that toggled on every wrap of a narrower register or divided by the wrong power of two would miss the count badly.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int PHASE_W_DEF = 20;

    typedef enum logic [1:0] {
        NCO_IDLE  = 2'd0,
        NCO_RUN   = 2'd1,
        NCO_CLEAR = 2'd2
    } nco_mode_e;

    function automatic nco_mode_e nco_decode(input logic enable, input logic clear);
        nco_mode_e m;
        if (clear)
            m = NCO_CLEAR;
        else if (enable)
            m = NCO_RUN;
        else
            m = NCO_IDLE;
        return m;
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int W = PHASE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  nco_mode_e    mode,
    input  logic [W-1:0] step,
    output logic         wrap
);

    localparam int SUM_W = W + 1;

    logic [W-1:0]     phase_q;
    logic [SUM_W-1:0] sum_w;

    assign sum_w = {1'b0, phase_q} + {1'b0, step};
    assign wrap  = (mode == NCO_RUN) && sum_w[W];

    always_ff @(posedge clk) begin
        if (rst || mode == NCO_CLEAR)
            phase_q <= '0;
        else if (mode == NCO_RUN)
            phase_q <= sum_w[W-1:0];
    end

    // R2: phase advances by the step modulo 2^W
    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == NCO_RUN) |=> (phase_q == W'($past(phase_q) + $past(step))));

    // R4: phase frozen while idle
    p_phase_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == NCO_IDLE) |=> $stable(phase_q));

    // R5: clear zeroes the phase
    p_phase_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == NCO_CLEAR) |=> (phase_q == '0));

endmodule

// File: rtl/nco_fixed_duty.sv
module nco_fixed_duty
    import nco_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  nco_mode_e mode,
    input  logic      wrap,
    output logic      level
);

    always_ff @(posedge clk) begin
        if (rst || mode != NCO_RUN)
            level <= 1'b0;
        else if (wrap)
            level <= ~level;
    end

    // R3: a carry flips the level
    p_flip_on_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == NCO_RUN && wrap) |=> (level != $past(level)));

    // R3: no carry, no change
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == NCO_RUN && !wrap) |=> $stable(level));

    // R4 and R5: output low when not running
    p_low_when_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        (mode != NCO_RUN) |=> !level);

endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen
    import nco_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic               phase_clr,
    input  logic [PHASE_W-1:0] tune_word,
    output logic               clk_out
);

    nco_mode_e mode;
    logic      wrap;

    assign mode = nco_decode(run_en, phase_clr);

    nco_phase_acc #(.W(PHASE_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .step (tune_word),
        .wrap (wrap)
    );

    nco_fixed_duty u_duty (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .wrap  (wrap),
        .level (clk_out)
    );

    // R6: zero word never moves the output while running
    p_zero_word_static_r6: assert property (@(posedge clk) disable iff (rst)
        (run_en && !phase_clr && tune_word == '0) |=> $stable(clk_out));

    // R1: output low right after reset
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !clk_out);

endmodule

// File: tb/nco_clkgen_tb.sv
module nco_clkgen_tb;

    localparam int  W    = 20;
    localparam longint MOD = longint'(1) << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic         phase_clr = 1'b0;
    logic [W-1:0] tune_word = '0;
    logic         clk_out;

    always #5 clk = ~clk;

    nco_clkgen #(.PHASE_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .phase_clr (phase_clr),
        .tune_word (tune_word),
        .clk_out   (clk_out)
    );

    typedef struct {
        logic  val;
        string req;
    } exp_t;

    exp_t   sb_q[$];
    int     checks = 0;
    int     fails  = 0;
    longint m_phase = 0;
    logic   m_out = 1'b0;
    int     edges = 0;
    int     highs = 0;
    logic   prev = 1'b0;
    bit     done = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // driver: apply one cycle of stimulus and push the modelled output
    task automatic step(input bit e, input bit c, input longint k, input string req);
        longint s;
        @(negedge clk);
        run_en    = e;
        phase_clr = c;
        tune_word = W'(k);
        if (c) begin
            m_phase = 0;
            m_out   = 1'b0;
        end else if (!e) begin
            m_out = 1'b0;
        end else begin
            s = m_phase + k;
            if (s >= MOD) m_out = ~m_out;
            m_phase = s % MOD;
        end
        sb_q.push_back('{val: m_out, req: req});
    endtask

    // monitor: sample after each rising edge and compare
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(clk_out === e.val, e.req, longint'(clk_out), longint'(e.val));
        end
        if (clk_out !== prev) edges++;
        if (clk_out === 1'b1) highs++;
        prev = clk_out;
    end

    task automatic settle();
        @(posedge clk);
        #4;
    endtask

    task automatic freq_run(input longint k, input int n, input string req);
        longint expv;
        step(1'b0, 1'b1, k, req);
        settle();
        edges = 0;
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, k, req);
        settle();
        expv = (longint'(n) * k) / MOD;
        check(longint'(edges) == expv, req, longint'(edges), expv);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check(clk_out === 1'b0, "R1", longint'(clk_out), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2/R3: basic carries with a 3/4 word
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 20'hC0000, "R3");
        // R2: odd word, many wraps
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 20'hFFFFF, "R2");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 20'h12345, "R2");

        // R4: hold with residual phase, then resume with a word that needs it
        step(1'b0, 1'b1, 0, "R5");
        step(1'b1, 1'b0, 20'hC0000, "R4");
        step(1'b1, 1'b0, 20'hC0000, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 20'h7FFFF, "R4");
        step(1'b1, 1'b0, 20'h80000, "R4");
        step(1'b1, 1'b0, 20'h80000, "R4");

        // R5: clear wins over enable
        step(1'b1, 1'b0, 20'hC0000, "R5");
        step(1'b1, 1'b1, 20'hC0000, "R5");
        step(1'b1, 1'b0, 20'h40000, "R5");
        step(1'b1, 1'b0, 20'h40000, "R5");
        step(1'b1, 1'b0, 20'h40000, "R5");
        step(1'b0, 1'b1, 20'h40000, "R5");

        // R6: zero word after reaching high level
        step(1'b1, 1'b0, 20'h80000, "R6");
        step(1'b1, 1'b0, 20'h80000, "R6");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 0, "R6");
        settle();
        edges = 0;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 0, "R6");
        settle();
        check(edges == 0, "R6", longint'(edges), 0);

        // R8: exact quarter-rate square wave
        step(1'b0, 1'b1, 0, "R8");
        settle();
        highs = 0;
        edges = 0;
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 20'h80000, "R8");
        settle();
        check(highs == 8, "R8", longint'(highs), 8);
        check(edges == 8, "R8", longint'(edges), 8);

        // R7: serial-rate tuning words
        freq_run(120796, 2048, "R7");
        freq_run(241592, 2048, "R7");
        freq_run(10066,  2048, "R7");
        freq_run(2517,   2048, "R7");

        settle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(10 * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule